// File: doc/BRIEF.md
# SIMD Widening Shift-Left Unit

This vector execution unit turns narrow integer elements into elements of twice the width and shifts each one left by an immediate amount. It works on 128-bit lanes. In each lane only the lower 64 bits of the source are read. Each element there is sign-extended or zero-extended to double width and shifted left. The results fill the whole lane. A separate quad-extend mode widens the lane's single low 64-bit element to a full 128-bit result.

The unit serves a 256-bit register. An operation-size select chooses between a 128-bit form, which writes the lower lane and zeroes the upper one, and a 256-bit form, which handles both lanes the same way. Every field of the result comes from the source captured in a single cycle, so the destination may be the same register as the source. The result is registered, so the latency is one cycle, and it comes with a valid flag.

Top module: `simd_widen_shl`

## Requirements
- R1: A result is registered at the rising edge where `in_valid` is 1. `out_valid` is 1 in the cycle after an accepted operation and 0 otherwise. While `in_valid` is 0, `dst` keeps its value.
- R2: A synchronous active-low reset sets `dst` to all zeros and `out_valid` to 0.
- R3: `esize` encodes the size pair as follows: 0 is byte to halfword, 1 is halfword to word, 2 is word to doubleword. Destination element i of a lane comes from source element i of the same lane, taken from that lane's low 64 bits. Lane bits 127:64 are ignored.
- R4: When `is_signed` is 1, each source element is sign-extended. When it is 0, each source element is zero-extended.
- R5: The shift amount is the low 3 bits of `shamt` for byte sources, the low 4 bits for halfword sources and all 5 bits for word sources. Any higher `shamt` bits have no effect. Bits shifted past the destination element width are lost.
- R6: When `wide256` is 0, `dst[255:128]` is zero and `src[255:128]` has no effect.
- R7: When `wide256` is 1, the upper lane produces its elements from `src[191:128]` in the same way as the lower lane does, and places them in `dst[255:128]`.
- R8: When `quad_mode` is 1, `src[63:0]` is extended to 128 bits (signed or unsigned per `is_signed`) and written to `dst[127:0]`. With `wide256` set, `src[191:128]` is also extended and written to `dst[255:128]`. In this mode `esize` and `shamt` have no effect.
- R9: When `quad_mode` is 0 and `esize` is 3 (reserved), every enabled lane produces zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Accepts an operation this cycle |
| src | input | 256 | Source vector |
| shamt | input | 5 | Immediate shift amount |
| esize | input | 2 | Size pair: 0 byte to halfword, 1 halfword to word, 2 word to doubleword, 3 reserved |
| is_signed | input | 1 | 1 sign-extends, 0 zero-extends |
| wide256 | input | 1 | 1 selects the 256-bit form, 0 the 128-bit form |
| quad_mode | input | 1 | 1 selects the 64-to-128-bit extend |
| out_valid | output | 1 | `dst` holds a fresh result |
| dst | output | 256 | Destination vector |

## Verification
Every result is due exactly one rising edge after the edge that sees `in_valid` high, and `out_valid` rises in that same cycle. The bench drives each operation on a falling edge and lowers `in_valid` on the next falling edge. It compares `dst` and `out_valid` at that point, half a period after the capturing edge. The hold checks change `src` while `in_valid` is low and sample after a full cycle has passed. This shows that nothing moved.

// File: rtl/widen_pkg.sv
// Package: shared types for the widening shift-left unit.
// Assumes the encoding of the size pair given in the brief.
package widen_pkg;
    typedef enum logic [1:0] {
        SZ_B2H  = 2'd0,
        SZ_H2W  = 2'd1,
        SZ_W2D  = 2'd2,
        SZ_RSVD = 2'd3
    } wsize_e;

    localparam int NUM_SIZES = 3;
endpackage

// File: rtl/widen_lane.sv
// Module: widen_lane
// Combinational widening shift of one lane. Reads the low half of the
// lane, builds the result for every size pair in parallel, then picks
// one by size or by quad mode. Assumes LANE_W is 128.
module widen_lane
    import widen_pkg::*;
#(
    parameter int LANE_W = 128,
    parameter int SH_W   = 5
) (
    input  logic [LANE_W/2-1:0] half_src,
    input  wsize_e              esize,
    input  logic                is_signed,
    input  logic                quad_mode,
    input  logic [SH_W-1:0]     shamt,
    output logic [LANE_W-1:0]   lane_dst
);
    localparam int HALF = LANE_W / 2;

    logic [LANE_W-1:0] cand [NUM_SIZES];
    logic [LANE_W-1:0] quad_res;

    // one candidate result per size pair
    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        localparam int SW = 8 << s;
        localparam int DW = 2 * SW;
        localparam int NE = HALF / SW;
        logic [LANE_W-1:0] part;
        for (genvar e = 0; e < NE; e++) begin : g_elem
            logic [SW-1:0] narrow;
            logic [DW-1:0] ext;
            assign narrow = half_src[e*SW +: SW];
            assign ext = is_signed ? {{SW{narrow[SW-1]}}, narrow}
                                   : {{SW{1'b0}}, narrow};
            assign part[e*DW +: DW] = ext << shamt[s+2:0];
        end
        assign cand[s] = part;
    end

    // extend the low half to a full lane
    assign quad_res = is_signed ? {{HALF{half_src[HALF-1]}}, half_src}
                                : {{HALF{1'b0}}, half_src};

    // choose the lane result
    always_comb begin
        if (quad_mode) begin
            lane_dst = quad_res;
        end else begin
            case (esize)
                SZ_B2H:  lane_dst = cand[0];
                SZ_H2W:  lane_dst = cand[1];
                SZ_W2D:  lane_dst = cand[2];
                default: lane_dst = '0;
            endcase
        end
    end
endmodule

// File: rtl/simd_widen_shl.sv
// Module: simd_widen_shl
// Vector widening shift-left with a one-cycle registered output.
// Lane 0 is always computed. The lanes above it are computed only in
// the 256-bit form and are zero otherwise. Assumes VEC_W is a multiple
// of LANE_W.
module simd_widen_shl
    import widen_pkg::*;
#(
    parameter int VEC_W  = 256,
    parameter int LANE_W = 128,
    parameter int SH_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [VEC_W-1:0]  src,
    input  logic [SH_W-1:0]   shamt,
    input  logic [1:0]        esize,
    input  logic              is_signed,
    input  logic              wide256,
    input  logic              quad_mode,
    output logic              out_valid,
    output logic [VEC_W-1:0]  dst
);
    localparam int NUM_LANES = VEC_W / LANE_W;
    localparam int HALF      = LANE_W / 2;

    logic [VEC_W-1:0] next_dst;
    logic [NUM_LANES-1:0] unused_src_hi;
    wsize_e esize_t;

    assign esize_t = wsize_e'(esize);

    // one lane engine per lane, gated by the operation size
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        logic [LANE_W-1:0] lane_res;
        widen_lane #(.LANE_W(LANE_W), .SH_W(SH_W)) u_lane (
            .half_src  (src[l*LANE_W +: HALF]),
            .esize     (esize_t),
            .is_signed (is_signed),
            .quad_mode (quad_mode),
            .shamt     (shamt),
            .lane_dst  (lane_res)
        );
        if (l == 0) begin : g_low
            assign next_dst[l*LANE_W +: LANE_W] = lane_res;
        end else begin : g_up
            assign next_dst[l*LANE_W +: LANE_W] = wide256 ? lane_res : '0;
        end
        assign unused_src_hi[l] = ^src[l*LANE_W+HALF +: HALF];
    end

    // output register and valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst       <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                dst <= next_dst;
            end
        end
    end
endmodule

// File: rtl/simd_widen_shl_chk.sv
// Module: simd_widen_shl_chk
// Property checker bound to simd_widen_shl. Observes the ports only.
module simd_widen_shl_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         src_b63,
    input logic [2:0]   shamt_lo,
    input logic [1:0]   esize,
    input logic         is_signed,
    input logic         wide256,
    input logic         quad_mode,
    input logic         out_valid,
    input logic [255:0] dst
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R1
    hold_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && $past(rst_n)) |=> $stable(dst));
    // R6
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide256) |=> (dst[255:128] == '0));
    // R8
    quad_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && quad_mode && !is_signed) |=> (dst[127:64] == '0));
    // R8
    quad_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && quad_mode && is_signed) |=> (dst[127:64] == {64{$past(src_b63)}}));
    // R4
    byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !quad_mode && esize == 2'd0 && !is_signed && shamt_lo == 3'd0)
        |=> (dst[15:8] == 8'h00));
    // R9
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !quad_mode && esize == 2'd3) |=> (dst == '0));
endmodule

bind simd_widen_shl simd_widen_shl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .src_b63   (src[63]),
    .shamt_lo  (shamt[2:0]),
    .esize     (esize),
    .is_signed (is_signed),
    .wide256   (wide256),
    .quad_mode (quad_mode),
    .out_valid (out_valid),
    .dst       (dst)
);

// File: tb/simd_widen_shl_test.sv
module simd_widen_shl_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [255:0] src;
        logic [4:0]   shamt;
        logic [1:0]   esize;
        logic         sgn;
        logic         wide;
        logic         quad;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{256'h0123_4567_89AB_CDEF_F0E1_D2C3_B4A5_9687_FEDC_BA98_7654_3210_8899_AABB_CCDD_EEFF, 5'd0, 2'd0, 1'b1, 1'b1, 1'b0},
        '{256'h0123_4567_89AB_CDEF_F0E1_D2C3_B4A5_9687_FEDC_BA98_7654_3210_8899_AABB_CCDD_EEFF, 5'd7, 2'd0, 1'b0, 1'b1, 1'b0},
        '{256'hDEAD_BEEF_CAFE_F00D_8000_7FFF_0001_FFFF_1111_2222_3333_4444_8001_7FFE_C000_0003, 5'd15, 2'd1, 1'b1, 1'b1, 1'b0},
        '{256'hDEAD_BEEF_CAFE_F00D_8000_7FFF_0001_FFFF_1111_2222_3333_4444_8001_7FFE_C000_0003, 5'd21, 2'd1, 1'b0, 1'b0, 1'b0},
        '{256'h5555_AAAA_5555_AAAA_8000_0001_7FFF_FFFF_0F0F_0F0F_F0F0_F0F0_FFFF_FFFF_8000_0000, 5'd31, 2'd2, 1'b1, 1'b1, 1'b0},
        '{256'h5555_AAAA_5555_AAAA_8000_0001_7FFF_FFFF_0F0F_0F0F_F0F0_F0F0_FFFF_FFFF_8000_0000, 5'd3,  2'd2, 1'b0, 1'b1, 1'b0},
        '{256'h1234_5678_9ABC_DEF0_8765_4321_0FED_CBA9_1357_9BDF_2468_ACE0_FFFF_0000_FFFF_0000, 5'd11, 2'd0, 1'b1, 1'b0, 1'b0},
        '{256'h1234_5678_9ABC_DEF0_8765_4321_0FED_CBA9_1357_9BDF_2468_ACE0_FFFF_0000_FFFF_0000, 5'd19, 2'd1, 1'b1, 1'b1, 1'b0},
        '{256'h1234_5678_9ABC_DEF0_8765_4321_0FED_CBA9_1357_9BDF_2468_ACE0_FFFF_0000_FFFF_0000, 5'd9,  2'd2, 1'b1, 1'b1, 1'b1},
        '{256'h1234_5678_9ABC_DEF0_8765_4321_0FED_CBA9_1357_9BDF_2468_ACE0_FFFF_0000_FFFF_0000, 5'd9,  2'd0, 1'b0, 1'b1, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [255:0] src = '0;
    logic [4:0]   shamt = '0;
    logic [1:0]   esize = '0;
    logic         is_signed = 1'b0;
    logic         wide256 = 1'b0;
    logic         quad_mode = 1'b0;
    logic         out_valid;
    logic [255:0] dst;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    simd_widen_shl uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src),
        .shamt(shamt), .esize(esize), .is_signed(is_signed),
        .wide256(wide256), .quad_mode(quad_mode),
        .out_valid(out_valid), .dst(dst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // model built from the requirement text
    function automatic logic [255:0] model(vec_t v);
        logic [255:0] r = '0;
        for (int ln = 0; ln < 2; ln++) begin
            int base = ln * 128;
            if (ln == 1 && !v.wide) continue;
            if (v.quad) begin
                logic [63:0] h = v.src[base +: 64];
                for (int b = 0; b < 64; b++) r[base+b] = h[b];
                for (int b = 64; b < 128; b++) r[base+b] = v.sgn ? h[63] : 1'b0;
            end else if (v.esize != 2'd3) begin
                int sw = 8 << v.esize;
                int dw = 2 * sw;
                int sh = int'(v.shamt) & ((1 << (3 + v.esize)) - 1);
                for (int e = 0; e < 64 / sw; e++) begin
                    logic [63:0] x = '0;
                    for (int b = 0; b < sw; b++) x[b] = v.src[base + e*sw + b];
                    if (v.sgn && x[sw-1])
                        for (int b = sw; b < 64; b++) x[b] = 1'b1;
                    x = x << sh;
                    for (int b = 0; b < dw; b++) r[base + e*dw + b] = x[b];
                end
            end
        end
        return r;
    endfunction

    task automatic check(string req, logic [255:0] got, logic [255:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic run_op(vec_t v);
        @(negedge clk);
        src = v.src; shamt = v.shamt; esize = v.esize;
        is_signed = v.sgn; wide256 = v.wide; quad_mode = v.quad;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic directed(string req, vec_t v, logic [255:0] exp);
        run_op(v);
        check(req, {255'd0, out_valid}, 256'd1);
        check(req, dst, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R2 reset state
        check("R2 out_valid", {255'd0, out_valid}, '0);
        check("R2 dst", dst, '0);
        rst_n = 1'b1;

        // table walk covering R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            run_op(TBL[i]);
            check("R1 valid", {255'd0, out_valid}, 256'd1);
            check("R3/R4/R5 table", dst, model(TBL[i]));
        end

        // R4 signed byte extend then shift
        directed("R4 sext", '{256'h80, 5'd1, 2'd0, 1'b1, 1'b0, 1'b0}, 256'hFF00);
        // R4 unsigned
        directed("R4 zext", '{256'h80, 5'd1, 2'd0, 1'b0, 1'b0, 1'b0}, 256'h100);
        // R5 upper shamt bits dropped for byte source
        directed("R5 mask", '{256'h01, 5'd9, 2'd0, 1'b0, 1'b0, 1'b0}, 256'h2);
        // R5 word source shift 31
        directed("R5 w31", '{256'h1, 5'd31, 2'd2, 1'b0, 1'b0, 1'b0}, 256'h8000_0000);
        // R3 lane bits 127:64 ignored
        directed("R3 hi half", '{{128'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7F}, 5'd0, 2'd0, 1'b1, 1'b0, 1'b0}, 256'h7F);
        // R7 upper lane taken from src[191:128], src[255:192] ignored
        directed("R7 upper", '{{64'hFFFF_FFFF_FFFF_FFFF, 64'hFF, 128'd0}, 5'd0, 2'd0, 1'b0, 1'b1, 1'b0},
                 {112'd0, 16'h00FF, 128'd0});
        // R6 narrow form clears the upper lane
        directed("R6 narrow", '{{64'd0, 64'hFF, 128'd0}, 5'd0, 2'd0, 1'b0, 1'b0, 1'b0}, '0);
        // R8 quad, signed, wide, esize and shamt ignored
        directed("R8 quad", '{{64'd0, 64'h1, 64'd0, 64'h8000_0000_0000_0000}, 5'd31, 2'd3, 1'b1, 1'b1, 1'b1},
                 {64'd0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000});
        // R9 reserved size gives zero
        directed("R9 rsvd", '{{256{1'b1}}, 5'd0, 2'd3, 1'b1, 1'b1, 1'b0}, '0);

        // R1 hold while idle
        run_op('{256'h3, 5'd0, 2'd0, 1'b0, 1'b0, 1'b0});
        src = {256{1'b1}}; esize = 2'd2;
        @(negedge clk);
        check("R1 hold valid", {255'd0, out_valid}, '0);
        check("R1 hold dst", dst, 256'h3);

        // R2 reset clears a loaded result
        rst_n = 1'b0;
        @(negedge clk);
        check("R2 re-reset", dst, '0);
        check("R2 re-reset valid", {255'd0, out_valid}, '0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                failures++;
                $display("FAIL watchdog got=timeout exp=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule